// File: doc/BRIEF.md
# MII receive status generator

This block produces the four receive-side status and data outputs of one media-independent interface channel: carrier sense, receive data valid, the receive data nibble and receive error. It sits after a line decoder, which reports frame boundaries, decoded nibbles with a valid flag, a per-nibble error flag and the link-fail condition. The block turns these event pulses into the level-style outputs a MAC expects.

Decoder events are sampled on the rising edge of the receive clock, which runs at 25 MHz in 100 Mbps operation. Every output is launched on the following falling edge. A consumer latching on the next rising edge therefore sees stable values with half a clock period of setup margin. Outside a packet the data nibble is clamped to zero. While the link has failed, no carrier is reported, whatever the decoder says.

Top module: `mii_rx_status`

## Requirements
- R1: While rst_ni is low, crs_o, rxdv_o and rxer_o are 0 and rxd_o is 0, including when reset arrives in the middle of a packet. The cleared state takes effect without waiting for a clock edge.
- R2: While no packet is in progress, crs_o and rxdv_o are 0 and rxd_o is 0. Any nibble, valid flag or error flag presented then has no effect on the outputs.
- R3: A start pulse (sop_i=1) sampled on a rising edge while idle and with link_fail_i=0 opens a packet. crs_o is 1 from the next falling edge. A start pulse during a packet is ignored.
- R4: During a packet, a nibble sampled with nib_vld_i=1 appears on rxd_o together with rxdv_o=1 from the next falling edge, for one full clock period. A packet cycle with nib_vld_i=0 gives crs_o=1, rxdv_o=0 and rxd_o=0.
- R5: An end pulse (eop_i=1) sampled during a packet closes it. From the next falling edge crs_o, rxdv_o and rxer_o are 0 and rxd_o is 0, and the nibble of that cycle is dropped. An end pulse while idle is ignored.
- R6: rxer_o is 1 for exactly the clock period in which a nibble sampled with nib_vld_i=1 and nib_err_i=1 during a packet is on rxd_o. nib_err_i without nib_vld_i, or outside a packet, has no effect.
- R7: link_fail_i=1 sampled on a rising edge forces crs_o, rxdv_o and rxer_o to 0 and rxd_o to 0 at the next falling edge, and aborts any packet in progress. While link_fail_i is 1, start pulses are ignored. After it clears, a new start pulse is needed before carrier returns.
- R8: rxdv_o is never 1 while crs_o is 0, and rxer_o is never 1 while rxdv_o is 0.
- R9: A start pulse and an end pulse sampled together while idle open the packet; the end pulse is ignored. A valid nibble in that same cycle is delivered as the first data.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Receive clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| sop_i | input | 1 | Start-of-packet pulse from decoder |
| eop_i | input | 1 | End-of-packet pulse from decoder |
| nib_i | input | NIB_W | Decoded data nibble |
| nib_vld_i | input | 1 | nib_i holds packet data this cycle |
| nib_err_i | input | 1 | nib_i is errored this cycle |
| link_fail_i | input | 1 | Channel is in link-fail state |
| crs_o | output | 1 | Carrier sense, launched on falling edge |
| rxdv_o | output | 1 | Receive data valid, launched on falling edge |
| rxd_o | output | NIB_W | Receive data nibble, zero outside data |
| rxer_o | output | 1 | Receive error, launched on falling edge |

## Verification
Some properties are checked by assertions on every rising edge, sampled while the outputs sit half a period after launch. These are the output ordering invariants, the zero clamp on rxd_o whenever rxdv_o is low, and the link-fail squelch. They also check that start, end and data nibbles sampled on one edge show up on the following launch, and that rxer_o always traces back to an errored valid nibble. The bench scenarios alone show the following: that a start pulse is needed again after a link failure, that repeated start or end pulses are ignored, the same-cycle start and end case, and the asynchronous clear in the middle of a packet.

// File: rtl/mii_rx_pkg.sv
package mii_rx_pkg;
  localparam int unsigned MII_NIB_W = 4;

  typedef enum logic {
    RX_IDLE = 1'b0,
    RX_PKT  = 1'b1
  } rx_state_e;
endpackage

// File: rtl/mii_rx_nib_gate.sv
// Forms staged output values for one cycle from frame activity and nibble flags.
module mii_rx_nib_gate #(
  parameter int unsigned NIB_W = mii_rx_pkg::MII_NIB_W
) (
  input  logic             active_i,
  input  logic [NIB_W-1:0] nib_i,
  input  logic             nib_vld_i,
  input  logic             nib_err_i,
  output logic             crs_o,
  output logic             dv_o,
  output logic [NIB_W-1:0] rxd_o,
  output logic             er_o
);
  logic take;

  always_comb begin
    take  = active_i & nib_vld_i;
    crs_o = active_i;
    dv_o  = take;
    rxd_o = take ? nib_i : '0;
    er_o  = take & nib_err_i;
  end
endmodule

// File: rtl/mii_rx_frame_track.sv
// Rising-edge stage: packet state and staged output values.
module mii_rx_frame_track
  import mii_rx_pkg::*;
#(
  parameter int unsigned NIB_W = MII_NIB_W
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             sop_i,
  input  logic             eop_i,
  input  logic [NIB_W-1:0] nib_i,
  input  logic             nib_vld_i,
  input  logic             nib_err_i,
  input  logic             link_fail_i,
  output logic             crs_q_o,
  output logic             dv_q_o,
  output logic [NIB_W-1:0] rxd_q_o,
  output logic             er_q_o
);
  rx_state_e state_q, state_d;
  logic active;
  logic g_crs, g_dv, g_er;
  logic [NIB_W-1:0] g_rxd;

  always_comb begin
    state_d = state_q;
    active  = 1'b0;
    if (link_fail_i) begin
      state_d = RX_IDLE;
    end else if (state_q == RX_PKT) begin
      if (eop_i) state_d = RX_IDLE;
      else       active  = 1'b1;
    end else if (sop_i) begin
      // eop in the same cycle is ignored while idle
      state_d = RX_PKT;
      active  = 1'b1;
    end
  end

  mii_rx_nib_gate #(.NIB_W(NIB_W)) u_gate (
    .active_i (active),
    .nib_i    (nib_i),
    .nib_vld_i(nib_vld_i),
    .nib_err_i(nib_err_i),
    .crs_o    (g_crs),
    .dv_o     (g_dv),
    .rxd_o    (g_rxd),
    .er_o     (g_er)
  );

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      state_q <= RX_IDLE;
      crs_q_o <= 1'b0;
      dv_q_o  <= 1'b0;
      rxd_q_o <= '0;
      er_q_o  <= 1'b0;
    end else begin
      state_q <= state_d;
      crs_q_o <= g_crs;
      dv_q_o  <= g_dv;
      rxd_q_o <= g_rxd;
      er_q_o  <= g_er;
    end
  end
endmodule

// File: rtl/mii_rx_launch.sv
// Falling-edge launch registers, giving half a period of setup to the consumer.
module mii_rx_launch #(
  parameter int unsigned NIB_W = mii_rx_pkg::MII_NIB_W
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             crs_i,
  input  logic             dv_i,
  input  logic [NIB_W-1:0] rxd_i,
  input  logic             er_i,
  output logic             crs_o,
  output logic             rxdv_o,
  output logic [NIB_W-1:0] rxd_o,
  output logic             rxer_o
);
  always_ff @(negedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      crs_o  <= 1'b0;
      rxdv_o <= 1'b0;
      rxd_o  <= '0;
      rxer_o <= 1'b0;
    end else begin
      crs_o  <= crs_i;
      rxdv_o <= dv_i;
      rxd_o  <= rxd_i;
      rxer_o <= er_i;
    end
  end
endmodule

// File: rtl/mii_rx_status.sv
module mii_rx_status
  import mii_rx_pkg::*;
#(
  parameter int unsigned NIB_W = MII_NIB_W
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             sop_i,
  input  logic             eop_i,
  input  logic [NIB_W-1:0] nib_i,
  input  logic             nib_vld_i,
  input  logic             nib_err_i,
  input  logic             link_fail_i,
  output logic             crs_o,
  output logic             rxdv_o,
  output logic [NIB_W-1:0] rxd_o,
  output logic             rxer_o
);
  logic             crs_q, dv_q, er_q;
  logic [NIB_W-1:0] rxd_q;

  mii_rx_frame_track #(.NIB_W(NIB_W)) u_track (
    .clk_i      (clk_i),
    .rst_ni     (rst_ni),
    .sop_i      (sop_i),
    .eop_i      (eop_i),
    .nib_i      (nib_i),
    .nib_vld_i  (nib_vld_i),
    .nib_err_i  (nib_err_i),
    .link_fail_i(link_fail_i),
    .crs_q_o    (crs_q),
    .dv_q_o     (dv_q),
    .rxd_q_o    (rxd_q),
    .er_q_o     (er_q)
  );

  mii_rx_launch #(.NIB_W(NIB_W)) u_launch (
    .clk_i (clk_i),
    .rst_ni(rst_ni),
    .crs_i (crs_q),
    .dv_i  (dv_q),
    .rxd_i (rxd_q),
    .er_i  (er_q),
    .crs_o (crs_o),
    .rxdv_o(rxdv_o),
    .rxd_o (rxd_o),
    .rxer_o(rxer_o)
  );
endmodule

// File: rtl/mii_rx_status_chk.sv
module mii_rx_status_chk #(
  parameter int unsigned NIB_W = 4
) (
  input logic             clk_i,
  input logic             rst_ni,
  input logic             sop_i,
  input logic             eop_i,
  input logic [NIB_W-1:0] nib_i,
  input logic             nib_vld_i,
  input logic             nib_err_i,
  input logic             link_fail_i,
  input logic             crs_o,
  input logic             rxdv_o,
  input logic [NIB_W-1:0] rxd_o,
  input logic             rxer_o
);
  p_dv_needs_crs_r8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    rxdv_o |-> crs_o);

  p_er_needs_dv_r8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    rxer_o |-> rxdv_o);

  p_rxd_clamp_r2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !rxdv_o |-> (rxd_o == '0));

  p_link_squelch_r7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $past(link_fail_i) |-> (!crs_o && !rxdv_o && !rxer_o));

  p_sop_opens_r3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $past(sop_i && !link_fail_i && !crs_o) |-> crs_o);

  p_eop_closes_r5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $past(eop_i && crs_o) |-> (!crs_o && !rxdv_o && !rxer_o));

  p_data_follows_r4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $past(crs_o && nib_vld_i && !eop_i && !link_fail_i)
      |-> (rxdv_o && rxd_o == $past(nib_i)));

  p_er_source_r6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    rxer_o |-> $past(nib_err_i && nib_vld_i));
endmodule

bind mii_rx_status mii_rx_status_chk #(.NIB_W(NIB_W)) u_chk (
  .clk_i      (clk_i),
  .rst_ni     (rst_ni),
  .sop_i      (sop_i),
  .eop_i      (eop_i),
  .nib_i      (nib_i),
  .nib_vld_i  (nib_vld_i),
  .nib_err_i  (nib_err_i),
  .link_fail_i(link_fail_i),
  .crs_o      (crs_o),
  .rxdv_o     (rxdv_o),
  .rxd_o      (rxd_o),
  .rxer_o     (rxer_o)
);

// File: tb/tb_mii_rx_status.sv
`timescale 1ns/1ps
module tb_mii_rx_status;
  localparam int NIB_W = 4;

  logic clk = 1'b0;
  logic rst_ni = 1'b1;
  logic sop, eop, vld, err, lf;
  logic [NIB_W-1:0] nib;
  logic crs, rxdv, rxer;
  logic [NIB_W-1:0] rxd;

  int checks = 0;
  int errors = 0;
  bit done = 0;

  // reference model state
  bit m_in_pkt;
  logic e_crs, e_dv, e_er;
  logic [NIB_W-1:0] e_rxd;

  always #4 clk = ~clk;

  mii_rx_status #(.NIB_W(NIB_W)) dut (
    .clk_i(clk), .rst_ni(rst_ni), .sop_i(sop), .eop_i(eop), .nib_i(nib),
    .nib_vld_i(vld), .nib_err_i(err), .link_fail_i(lf),
    .crs_o(crs), .rxdv_o(rxdv), .rxd_o(rxd), .rxer_o(rxer)
  );

  task automatic chk(string tag, string what, logic [NIB_W-1:0] act, logic [NIB_W-1:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s %s: actual %0h expected %0h at %0t", tag, what, act, exp, $time);
    end
  endtask

  task automatic chk_all(string tag);
    chk(tag, "crs", {3'b0, crs}, {3'b0, e_crs});
    chk(tag, "rxdv", {3'b0, rxdv}, {3'b0, e_dv});
    chk(tag, "rxd", rxd, e_rxd);
    chk(tag, "rxer", {3'b0, rxer}, {3'b0, e_er});
    chk("R8", "order", {3'b0, (rxdv & ~crs) | (rxer & ~rxdv)}, 4'h0);
  endtask

  task automatic set_idle_exp();
    e_crs = 0; e_dv = 0; e_rxd = '0; e_er = 0;
  endtask

  // drive one cycle of decoder events, update model, check after launch edge
  task automatic step(string tag, logic s, logic e, logic v, logic [NIB_W-1:0] n, logic r, logic l);
    sop = s; eop = e; vld = v; nib = n; err = r; lf = l;
    if (l) begin
      m_in_pkt = 0; set_idle_exp();
    end else if (m_in_pkt && e) begin
      m_in_pkt = 0; set_idle_exp();
    end else if (m_in_pkt || s) begin
      m_in_pkt = 1;
      e_crs = 1; e_dv = v; e_rxd = v ? n : '0; e_er = v & r;
    end else begin
      set_idle_exp();
    end
    @(posedge clk);
    // before the falling edge the previous values must still be held (R4 full period)
    @(negedge clk);
    #1;
    chk_all(tag);
  endtask

  initial begin
    #150000;
    if (!done) begin
      checks++;
      errors++;
      $display("FAIL watchdog: actual hung expected finish");
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end

  initial begin
    sop = 0; eop = 0; vld = 0; nib = '0; err = 0; lf = 0;
    m_in_pkt = 0; set_idle_exp();
    #1 rst_ni = 1'b0;
    #1 chk_all("R1");
    repeat (3) @(negedge clk);
    #1 rst_ni = 1'b1;
    chk_all("R1");

    // R2 idle: nibbles and errors ignored
    step("R2", 0, 0, 1, 4'hA, 1, 0);
    step("R2", 0, 0, 1, 4'h5, 0, 0);
    // R5 end pulse while idle ignored
    step("R5", 0, 1, 1, 4'hF, 0, 0);

    // R3 open without data
    step("R3", 1, 0, 0, 4'h7, 0, 0);
    // R4 data patterns
    for (int i = 0; i < 16; i++) step("R4", 0, 0, 1, 4'(i ^ 9), 0, 0);
    step("R4", 0, 0, 0, 4'hC, 0, 0);
    step("R4", 0, 0, 1, 4'h0, 0, 0);
    // R6 one errored nibble, then clean
    step("R6", 0, 0, 1, 4'h3, 1, 0);
    step("R6", 0, 0, 1, 4'h4, 0, 0);
    step("R6", 0, 0, 0, 4'h4, 1, 0);
    // R3 start while in packet ignored
    step("R3", 1, 0, 1, 4'hE, 0, 0);
    // R5 close; nibble dropped
    step("R5", 0, 1, 1, 4'hB, 1, 0);
    step("R5", 0, 0, 1, 4'h2, 0, 0);

    // R9 start and end together while idle
    step("R9", 1, 1, 1, 4'h6, 0, 0);
    step("R9", 0, 0, 1, 4'h8, 1, 0);
    step("R9", 0, 1, 0, 4'h0, 0, 0);

    // R7 link fail mid packet
    step("R7", 1, 0, 1, 4'h1, 0, 0);
    step("R7", 0, 0, 1, 4'hD, 1, 0);
    step("R7", 0, 0, 1, 4'h9, 1, 1);
    step("R7", 1, 0, 1, 4'h9, 0, 1);
    step("R7", 0, 0, 1, 4'h5, 0, 0);
    step("R7", 1, 0, 1, 4'h5, 0, 0);
    step("R7", 0, 1, 0, 4'h0, 0, 0);

    // R1 asynchronous clear in mid packet
    step("R1", 1, 0, 1, 4'hF, 1, 0);
    step("R1", 0, 0, 1, 4'hA, 0, 0);
    rst_ni = 1'b0;
    m_in_pkt = 0; set_idle_exp();
    #1 chk_all("R1");
    @(negedge clk);
    #1 rst_ni = 1'b1;
    step("R1", 0, 0, 1, 4'h3, 0, 0);
    step("R3", 1, 0, 1, 4'h3, 0, 0);
    step("R5", 0, 1, 0, 4'h0, 0, 0);

    done = 1;
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule